// File: doc/BRIEF.md
# Synchronous 512x9 FIFO with Read Rewind and Half-Full Flag

This block is a single-clock first-in first-out buffer of 512 words, each 9 bits wide. All nine bits are stored and returned exactly as written, so the top bit can carry parity or a control marker. The block generates the write and read addresses itself, so neither port takes an address. Words leave in the order they arrived.

The write side is a valid/ready stream. A word is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is low exactly while the buffer is full, and that is the only back-pressure. A producer that holds `in_valid` high while `in_ready` is low loses nothing already stored; its word is simply not taken. On the read side the consumer raises `out_req`. The request is accepted on an edge when the buffer is not empty and `rewind` is low. The word then appears on `out_data` in the next cycle, with a one-cycle `out_vld` pulse, and stays there until the next accepted read.

Three status flags report occupancy: `empty`, `full` and `half`. Raising `rewind` moves the read position back to the first word written since reset, so that stream can be replayed. It is meant for use before 512 words have ever been written after reset.

Top module: `fifo_rt`

## Requirements
- R1: While `rst_n` is low and in the first cycle after release, `empty`=1, `full`=0, `half`=0, `out_vld`=0 and `out_data`=0. Reset discards all stored words and returns both positions to the start.
- R2: Words are read out in write order, with all 9 bits (bit 8 included) unchanged.
- R3: A write attempted while `full`=1 is not stored. It changes neither the occupancy nor the words read out later.
- R4: A read request while `empty`=1 is ignored: `out_vld` stays 0 in the next cycle and `out_data` keeps its value.
- R5: `empty`=1 exactly when the occupancy is 0, and `full`=1 exactly when the occupancy is 512.
- R6: `half`=1 exactly when the occupancy is 257 or more. It is 0 at 256 or below.
- R7: An accepted write and an accepted read in the same cycle leave the occupancy unchanged. With both requested on an empty buffer, only the write happens. With both requested on a full buffer, only the read happens.
- R8: An accepted read drives the word onto `out_data` with `out_vld`=1 in the next cycle. `out_data` then holds until the next accepted read, and `out_vld` is 0 in cycles with no accepted read.
- R9: In a cycle with `rewind`=1, any read request is ignored and a write is still accepted. The next read returns the first word written since reset, and the occupancy becomes the number of words written since reset, with all flags following. This is guaranteed only when that number stays below 512.
- R10: `in_ready` equals the inverse of `full` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | Buffer can take a word (not full) |
| in_data | input | 9 | Word to be written |
| out_req | input | 1 | Consumer requests the next word |
| out_vld | output | 1 | `out_data` was refreshed by a read accepted in the previous cycle |
| out_data | output | 9 | Last word read; holds between reads |
| rewind | input | 1 | Move the read position back to the first word written since reset |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy is 512 |
| half | output | 1 | Occupancy is 257 or more |

## Verification
The bench keeps a behavioural model built on queues and compares against it in every cycle. The stimulus is chosen so that different faults show up differently:

- **Fill past capacity, then drain.** Distinct words with bit 8 toggling expose pointer wrap, dropped top bits and overflow corruption.
- **Simultaneous read and write at empty, full and mid-level.** Separates the three arbitration cases of R7.
- **A slow fill through 256 and 257 words.** Pins the `half` threshold to the exact boundary.
- **Rewind after a partial read, with a write in the same cycle, and rewind with nothing written.** Shows whether the recomputed occupancy and the replayed order are right.
- **A long random mix of requests.** Covers orderings that the directed patterns miss.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  localparam int FIFO_DEPTH = 512;
  localparam int FIFO_WIDTH = 9;

  function automatic int half_mark(input int depth);
    return depth / 2;
  endfunction
endpackage

// File: rtl/fifo_rt_ptrs.sv
module fifo_rt_ptrs #(
  parameter int AW = 9,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_acc,
  input  logic          rd_acc,
  input  logic          rewind,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count
);
  logic [AW-1:0] wr_nxt;
  logic [CW-1:0] cnt_nxt;

  assign wr_nxt = wr_acc ? wr_ptr + AW'(1) : wr_ptr;

  always_comb begin
    if (rewind) begin
      // after a rewind the occupancy is simply everything written since reset
      cnt_nxt = CW'(wr_ptr) + CW'(wr_acc);
    end else begin
      cnt_nxt = count + CW'(wr_acc) - CW'(rd_acc);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_nxt;
      count  <= cnt_nxt;
      if (rewind)      rd_ptr <= '0;
      else if (rd_acc) rd_ptr <= rd_ptr + AW'(1);
    end
  end
endmodule

// File: rtl/fifo_rt_mem.sv
module fifo_rt_mem #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9,
  parameter int AW    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    wa,
  input  logic [WIDTH-1:0] wd,
  input  logic             re,
  input  logic [AW-1:0]    ra,
  output logic [WIDTH-1:0] rd
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[wa] <= wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rd <= '0;
    else if (re) rd <= store[ra];
  end
endmodule

// File: rtl/fifo_rt_flags.sv
module fifo_rt_flags #(
  parameter int DEPTH = 512,
  parameter int CW    = 10,
  parameter int HALF  = 256
) (
  input  logic [CW-1:0] count,
  output logic          empty,
  output logic          full,
  output logic          half
);
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign half  = (count > CW'(HALF));
endmodule

// File: rtl/fifo_rt.sv
module fifo_rt
  import fifo_rt_pkg::*;
#(
  parameter int DEPTH = FIFO_DEPTH,
  parameter int WIDTH = FIFO_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  input  logic             out_req,
  output logic             out_vld,
  output logic [WIDTH-1:0] out_data,
  input  logic             rewind,
  output logic             empty,
  output logic             full,
  output logic             half
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = AW + 1;
  localparam int HALF = half_mark(DEPTH);

  logic          wr_acc;
  logic          rd_acc;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] count;

  assign wr_acc   = in_valid && !full;
  assign rd_acc   = out_req && !empty && !rewind;
  assign in_ready = !full;

  fifo_rt_ptrs #(.AW(AW), .CW(CW)) u_ptrs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_acc (wr_acc),
    .rd_acc (rd_acc),
    .rewind (rewind),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .count  (count)
  );

  fifo_rt_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_acc),
    .wa    (wr_ptr),
    .wd    (in_data),
    .re    (rd_acc),
    .ra    (rd_ptr),
    .rd    (out_data)
  );

  fifo_rt_flags #(.DEPTH(DEPTH), .CW(CW), .HALF(HALF)) u_flags (
    .count (count),
    .empty (empty),
    .full  (full),
    .half  (half)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= rd_acc;
  end
endmodule

// File: rtl/fifo_rt_chk.sv
module fifo_rt_chk #(
  parameter int WIDTH = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_req,
  input logic             rewind,
  input logic             out_vld,
  input logic [WIDTH-1:0] out_data,
  input logic             empty,
  input logic             full,
  input logic             half
);
  AST_EMPTY_FULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && in_valid && !out_req && !rewind) |=> full); // R3

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && out_req) |=> !out_vld); // R4

  AST_HALF_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> half); // R6

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> $stable(out_data)); // R8

  AST_BOTH_KEEP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !full && in_valid && out_req && !rewind)
      |=> ($stable(empty) && $stable(full) && $stable(half))); // R7
endmodule

bind fifo_rt fifo_rt_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .out_req  (out_req),
  .rewind   (rewind),
  .out_vld  (out_vld),
  .out_data (out_data),
  .empty    (empty),
  .full     (full),
  .half     (half)
);

// File: tb/fifo_rt_tb.sv
`timescale 1ns/1ps
module fifo_rt_tb;
  localparam int DEPTH = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [8:0] in_data = '0;
  logic       out_req = 1'b0;
  logic       out_vld;
  logic [8:0] out_data;
  logic       rewind = 1'b0;
  logic       empty;
  logic       full;
  logic       half;

  always #2.5 clk = ~clk;

  fifo_rt u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_req(out_req), .out_vld(out_vld),
    .out_data(out_data), .rewind(rewind), .empty(empty), .full(full),
    .half(half)
  );

  int total = 0;
  int bad = 0;
  logic [8:0] q[$];
  logic [8:0] hist[$];
  logic [8:0] e_data = '0;
  logic       e_vld = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    int n = q.size();
    chk(empty == (n == 0), "R5", "empty", empty, n == 0);
    chk(full == (n == DEPTH), "R5", "full", full, n == DEPTH);
    chk(half == (n >= 257), "R6", "half", half, n >= 257);
    chk(in_ready == (n != DEPTH), "R10", "in_ready", in_ready, n != DEPTH);
    chk(out_vld == e_vld, "R8", "out_vld", out_vld, e_vld);
    chk(out_data == e_data, "R2", "out_data", out_data, e_data);
  endtask

  task automatic step(input logic iv, input logic [8:0] d,
                      input logic rq, input logic rw);
    bit acc_w;
    bit acc_r;
    in_valid = iv; in_data = d; out_req = rq; rewind = rw;
    @(posedge clk);
    acc_w = iv && (q.size() != DEPTH);
    acc_r = rq && !rw && (q.size() != 0);
    e_vld = 1'b0;
    if (rw) begin
      q = hist;
    end else if (acc_r) begin
      e_data = q.pop_front();
      e_vld = 1'b1;
    end
    if (acc_w) begin
      q.push_back(d);
      hist.push_back(d);
    end
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    in_valid = 0; out_req = 0; rewind = 0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    q.delete(); hist.delete(); e_data = '0; e_vld = 1'b0;
    chk(empty && !full && !half && !out_vld && out_data == '0, "R1",
        "reset flags/data", {empty, full, half, out_vld}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(200000 * 5.0);
    bad++; total++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [8:0] keep;
    do_reset();

    // R4: reads on empty are ignored
    keep = out_data;
    repeat (3) step(0, '0, 1, 0);
    chk(!out_vld && out_data == keep, "R4", "read on empty", out_vld, 0);

    // R7: both requested on empty -> only the write
    step(1, 9'h155, 1, 0);
    chk(!empty && !out_vld, "R7", "both on empty", empty, 0);
    step(0, '0, 1, 0);

    // fill past capacity, bit 8 toggling
    for (int i = 0; i < DEPTH + 6; i++) step(1, 9'((i * 37) ^ (i << 8)), 0, 0);
    chk(full && !in_ready, "R3", "full blocks writes", in_ready, 0);
    // R7: both on full -> only the read
    step(1, 9'h1AA, 1, 0);
    chk(!full && out_vld, "R7", "both on full", full, 0);
    for (int i = 0; i < DEPTH + 4; i++) step(0, '0, 1, 0);
    chk(empty, "R2", "drained in order", empty, 1);

    // random mix; rewind occurs on its own test below
    for (int i = 0; i < 4000; i++)
      step(($urandom % 4) != 0, 9'($urandom), ($urandom % 3) == 0, 0);
    for (int i = 0; i < 200; i++)
      step(($urandom % 2) == 0, 9'($urandom), 1, 0);

    // half threshold and rewind
    do_reset();
    for (int i = 0; i < 256; i++) step(1, 9'(i + 100), 0, 0);
    chk(!half, "R6", "half at 256", half, 0);
    step(1, 9'h1F0, 0, 0);
    chk(half, "R6", "half at 257", half, 1);
    for (int i = 0; i < 43; i++) step(1, 9'(i ^ 9'h120), 0, 0);
    for (int i = 0; i < 120; i++) step(0, '0, 1, 0);
    chk(!half, "R6", "half after drain", half, 0);
    keep = out_data;
    step(1, 9'h0F5, 1, 1);
    chk(half && !out_vld && out_data == keep, "R9", "rewind with write",
        half, 1);
    step(0, '0, 1, 0);
    chk(out_data == 9'(100), "R9", "first word replayed", out_data, 100);
    for (int i = 0; i < 320; i++) step(0, '0, 1, 0);
    chk(empty, "R9", "replay length", empty, 1);
    for (int i = 0; i < 5; i++) step(0, '0, 0, 0);
    chk(out_data == e_data, "R8", "data held", out_data, e_data);

    // rewind with nothing written since reset
    do_reset();
    step(0, '0, 1, 1);
    chk(empty && !out_vld, "R9", "rewind on empty", empty, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule